// File: doc/BRIEF.md
# Snooping Eviction-Capture Cache Agent

This block sits on a shared processor bus as a passive second coherent agent. It keeps a direct-mapped cache filled only from the write-backs that the host processor places on the bus. When the host writes a modified line back to memory, the agent keeps a copy of that line. When the host later reads the same line, the agent claims it as modified in the snoop phase. It then sources the line as a cache-to-cache transfer, and the memory controller absorbs the same data.

Every bus input goes through one register stage before any logic uses it. A lookup reads the tag store and the line status on the following edge, and the snoop result is registered on the edge after that. A claimed line is driven as a burst of 64-bit beats. The burst begins only after the memory controller signals target-ready, because memory takes the data at the same time. The agent handles one transaction at a time. Bus arbitration, the memory controller and the host cache lie outside the block.

Top module: `snoop_capture_agent`

## Requirements
- R1: A synchronous reset drives all snoop and data handshake outputs low and marks every line invalid, so that a later read to any address gets no snoop response.
- R2: A request of kind 3 (write-back), followed by NBEATS beats flagged by `bus_din_valid`, stores the line at the index given by address bits [OFF_W +: IDX_W] together with the upper address bits as its tag, and marks it owned. Any line already held at that index is replaced.
- R3: A request of kind 0 (plain read) that matches an owned line pulses `snp_hitm` for one cycle, in the third cycle after the request is presented, and keeps `snp_hit` low.
- R4: After claiming a line, the agent holds the data outputs idle until `bus_trdy` is seen. On the second cycle after that it drives the NBEATS beats in ascending beat order on consecutive cycles, each marked by `bus_drdy`. `bus_dbsy` is high on every beat except the last, where it is low.
- R5: A plain read that hits an owned line leaves the line shared. A later plain read to a shared line pulses `snp_hit` with `snp_hitm` low, and no data is driven.
- R6: A request of kind 1 (full-line read with invalidate) that hits an owned line claims it and transfers it as in R3 and R4, and then invalidates it. If it hits a shared line, it raises no snoop output and invalidates the line.
- R7: A request of kind 2 (zero-byte invalidate) that hits raises no snoop output and invalidates the line.
- R8: A request whose tag differs from the stored tag, or whose line is invalid, raises no snoop output and starts no transfer.
- R9: When the final beat of a write-back is stored on the same edge that a lookup reads the same index, the lookup sees the contents before the write, and the write still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_valid | input | 1 | A request phase is present this cycle |
| bus_req_kind | input | 2 | 0 read, 1 read-invalidate, 2 zero-byte invalidate, 3 write-back |
| bus_req_addr | input | ADDR_W | Byte address of the request |
| bus_trdy | input | 1 | Memory controller ready to accept data |
| bus_din_valid | input | 1 | A write-back data beat is on `bus_din` |
| bus_din | input | 64 | Write-back data beat |
| snp_hit | output | 1 | Snoop result: line held clean |
| snp_hitm | output | 1 | Snoop result: line held modified, agent will source it |
| bus_dbsy | output | 1 | Data bus busy, low on the last beat |
| bus_drdy | output | 1 | Beat on `bus_dout` is valid |
| bus_dout | output | 64 | Cache-to-cache transfer data |

## Verification
The bench sweeps every index of a four-line cache with several tags. For each one it computes the expected beat values from the tag, index and beat number. Its checks target three kinds of error. A burst that starts before target-ready would show beats too early. An off-by-one in the read address would show repeated or shifted beats, and a misplaced busy signal would be seen as well. A missing owned-to-shared step would produce a second modified claim instead of a clean hit. An invalidate that is lost would produce a hit after a read-invalidate or a zero-byte invalidate. The bench also aims a lookup at the exact edge where a write-back completes. A design that bypassed the new contents would report a hit there when a miss is required. A reset that left valid bits standing would answer a read that follows it.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int unsigned BEAT_W = 64;

  typedef enum logic [1:0] {
    KIND_READ      = 2'd0,
    KIND_READ_INV  = 2'd1,
    KIND_INV_ZERO  = 2'd2,
    KIND_WRITEBACK = 2'd3
  } req_kind_e;
endpackage

// File: rtl/sca_sdp_ram.sv
module sca_sdp_ram #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // separate read port: same-address read returns the old word
  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sca_capture.sv
module sca_capture #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 19,
  parameter int unsigned BCNT_W = 2,
  parameter int unsigned NBEATS = 4,
  localparam int unsigned BEAT_W = sca_pkg::BEAT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [IDX_W-1:0]        start_idx,
  input  logic [TAG_W-1:0]        start_tag,
  input  logic                    beat_valid,
  input  logic [BEAT_W-1:0]       beat_data,
  output logic                    data_we,
  output logic [IDX_W+BCNT_W-1:0] data_waddr,
  output logic [BEAT_W-1:0]       data_wdata,
  output logic                    line_done,
  output logic [IDX_W-1:0]        line_idx,
  output logic [TAG_W-1:0]        line_tag
);
  localparam logic [BCNT_W-1:0] LAST = BCNT_W'(NBEATS - 1);

  logic              active;
  logic [BCNT_W-1:0] cnt;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;

  assign data_we    = active && beat_valid;
  assign data_waddr = {idx_q, cnt};
  assign data_wdata = beat_data;
  assign line_done  = data_we && (cnt == LAST);
  assign line_idx   = idx_q;
  assign line_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      idx_q  <= '0;
      tag_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      idx_q  <= start_idx;
      tag_q  <= start_tag;
    end else if (data_we) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) active <= 1'b0;
    end
  end
endmodule

// File: rtl/sca_responder.sv
module sca_responder #(
  parameter int unsigned LINES  = 256,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned TAG_W  = 19,
  parameter int unsigned BCNT_W = 2,
  parameter int unsigned NBEATS = 4,
  localparam int unsigned BEAT_W = sca_pkg::BEAT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  sca_pkg::req_kind_e      req_kind,
  input  logic [IDX_W-1:0]        req_idx,
  input  logic [TAG_W-1:0]        req_tag,
  input  logic                    trdy,
  input  logic [TAG_W-1:0]        tag_q,
  input  logic [BEAT_W-1:0]       data_q,
  input  logic                    fill_done,
  input  logic [IDX_W-1:0]        fill_idx,
  output logic [IDX_W+BCNT_W-1:0] data_raddr,
  output logic                    snp_hit,
  output logic                    snp_hitm,
  output logic                    dbsy,
  output logic                    drdy,
  output logic [BEAT_W-1:0]       dout
);
  import sca_pkg::*;

  localparam logic [BCNT_W-1:0] LAST = BCNT_W'(NBEATS - 1);

  typedef enum logic [1:0] {X_IDLE, X_WAIT, X_BEAT} xfer_e;

  logic [LINES-1:0] valid_r, owned_r;

  // lookup stage two
  logic             s2_valid, s2_v, s2_m;
  req_kind_e        s2_kind;
  logic [IDX_W-1:0] s2_idx;
  logic [TAG_W-1:0] s2_tag;

  xfer_e             xstate;
  logic [IDX_W-1:0]  xidx;
  logic [BCNT_W-1:0] cnt;
  logic              match, start_xfer, advance, last, clash;
  logic [BCNT_W-1:0] rd_beat;

  assign match = s2_valid && (s2_kind != KIND_WRITEBACK) && s2_v && (tag_q == s2_tag);
  assign start_xfer = match && s2_m && (xstate == X_IDLE) &&
                      ((s2_kind == KIND_READ) || (s2_kind == KIND_READ_INV));
  assign clash   = fill_done && (fill_idx == s2_idx);
  assign advance = ((xstate == X_WAIT) && trdy) || (xstate == X_BEAT);
  assign last    = (cnt == LAST);
  assign rd_beat = advance ? cnt + 1'b1 : cnt;
  assign data_raddr = (xstate == X_IDLE) ? {s2_idx, {BCNT_W{1'b0}}} : {xidx, rd_beat};

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_kind  <= KIND_READ;
      s2_idx   <= '0;
      s2_tag   <= '0;
      s2_v     <= 1'b0;
      s2_m     <= 1'b0;
    end else begin
      s2_valid <= req_valid;
      s2_kind  <= req_kind;
      s2_idx   <= req_idx;
      s2_tag   <= req_tag;
      s2_v     <= valid_r[req_idx];
      s2_m     <= owned_r[req_idx];
    end
  end

  // line status; a completing fill takes precedence over a snoop update
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      owned_r <= '0;
    end else begin
      if (match && !clash) begin
        if (s2_kind == KIND_READ) owned_r[s2_idx] <= 1'b0;
        else valid_r[s2_idx] <= 1'b0;
      end
      if (fill_done) begin
        valid_r[fill_idx] <= 1'b1;
        owned_r[fill_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_hit  <= 1'b0;
      snp_hitm <= 1'b0;
      drdy     <= 1'b0;
      dbsy     <= 1'b0;
      dout     <= '0;
      xstate   <= X_IDLE;
      xidx     <= '0;
      cnt      <= '0;
    end else begin
      snp_hitm <= start_xfer;
      snp_hit  <= match && !s2_m && (s2_kind == KIND_READ);
      drdy     <= 1'b0;
      dbsy     <= 1'b0;
      case (xstate)
        X_IDLE: begin
          if (start_xfer) begin
            xstate <= X_WAIT;
            xidx   <= s2_idx;
            cnt    <= '0;
          end
        end
        default: begin
          if (advance) begin
            drdy   <= 1'b1;
            dbsy   <= !last;
            dout   <= data_q;
            cnt    <= cnt + 1'b1;
            xstate <= last ? X_IDLE : X_BEAT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/snoop_capture_agent.sv
module snoop_capture_agent #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINES  = 256,
  parameter int unsigned NBEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req_valid,
  input  logic [1:0]        bus_req_kind,
  input  logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_trdy,
  input  logic              bus_din_valid,
  input  logic [63:0]       bus_din,
  output logic              snp_hit,
  output logic              snp_hitm,
  output logic              bus_dbsy,
  output logic              bus_drdy,
  output logic [63:0]       bus_dout
);
  import sca_pkg::*;

  localparam int unsigned BCNT_W = (NBEATS > 1) ? $clog2(NBEATS) : 1;
  localparam int unsigned OFF_W  = BCNT_W + 3;
  localparam int unsigned IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned DDEPTH = LINES << BCNT_W;

  // input register stage
  logic             r_valid, r_trdy, r_din_valid;
  req_kind_e        r_kind;
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic [63:0]      r_din;
  logic             addr_unused;

  assign addr_unused = ^bus_req_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      r_valid     <= 1'b0;
      r_kind      <= KIND_READ;
      r_idx       <= '0;
      r_tag       <= '0;
      r_trdy      <= 1'b0;
      r_din_valid <= 1'b0;
      r_din       <= '0;
    end else begin
      r_valid     <= bus_req_valid;
      r_kind      <= req_kind_e'(bus_req_kind);
      r_idx       <= bus_req_addr[OFF_W +: IDX_W];
      r_tag       <= bus_req_addr[ADDR_W-1 -: TAG_W];
      r_trdy      <= bus_trdy;
      r_din_valid <= bus_din_valid;
      r_din       <= bus_din;
    end
  end

  logic                    d_we, fill_done;
  logic [IDX_W+BCNT_W-1:0] d_waddr, d_raddr;
  logic [63:0]             d_wdata, d_q;
  logic [IDX_W-1:0]        fill_idx;
  logic [TAG_W-1:0]        fill_tag, t_q;

  sca_capture #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .BCNT_W(BCNT_W), .NBEATS(NBEATS)
  ) capture_i (
    .clk        (clk),
    .rst        (rst),
    .start      (r_valid && (r_kind == KIND_WRITEBACK)),
    .start_idx  (r_idx),
    .start_tag  (r_tag),
    .beat_valid (r_din_valid),
    .beat_data  (r_din),
    .data_we    (d_we),
    .data_waddr (d_waddr),
    .data_wdata (d_wdata),
    .line_done  (fill_done),
    .line_idx   (fill_idx),
    .line_tag   (fill_tag)
  );

  sca_sdp_ram #(.WIDTH(TAG_W), .DEPTH(LINES)) tag_ram_i (
    .clk   (clk),
    .we    (fill_done),
    .waddr (fill_idx),
    .wdata (fill_tag),
    .raddr (r_idx),
    .rdata (t_q)
  );

  sca_sdp_ram #(.WIDTH(64), .DEPTH(DDEPTH)) data_ram_i (
    .clk   (clk),
    .we    (d_we),
    .waddr (d_waddr),
    .wdata (d_wdata),
    .raddr (d_raddr),
    .rdata (d_q)
  );

  sca_responder #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BCNT_W(BCNT_W), .NBEATS(NBEATS)
  ) responder_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (r_valid),
    .req_kind   (r_kind),
    .req_idx    (r_idx),
    .req_tag    (r_tag),
    .trdy       (r_trdy),
    .tag_q      (t_q),
    .data_q     (d_q),
    .fill_done  (fill_done),
    .fill_idx   (fill_idx),
    .data_raddr (d_raddr),
    .snp_hit    (snp_hit),
    .snp_hitm   (snp_hitm),
    .dbsy       (bus_dbsy),
    .drdy       (bus_drdy),
    .dout       (bus_dout)
  );
endmodule

// File: rtl/snoop_capture_agent_chk.sv
module snoop_capture_agent_chk (
  input logic clk,
  input logic rst,
  input logic bus_trdy,
  input logic snp_hit,
  input logic snp_hitm,
  input logic bus_dbsy,
  input logic bus_drdy
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!snp_hit && !snp_hitm && !bus_drdy && !bus_dbsy));

  // R3
  a_r3_hit_kinds_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(snp_hit && snp_hitm));

  // R4
  a_r4_first_beat_after_trdy: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_drdy) |-> $past(bus_trdy, 2));

  // R4
  a_r4_busy_means_more: assert property (@(posedge clk) disable iff (rst)
    (bus_drdy && bus_dbsy) |=> bus_drdy);

  // R4
  a_r4_last_beat_ends: assert property (@(posedge clk) disable iff (rst)
    (bus_drdy && !bus_dbsy) |=> !bus_drdy);

  // R4
  a_r4_busy_only_with_beat: assert property (@(posedge clk) disable iff (rst)
    bus_dbsy |-> bus_drdy);
endmodule

bind snoop_capture_agent snoop_capture_agent_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_trdy (bus_trdy),
  .snp_hit  (snp_hit),
  .snp_hitm (snp_hitm),
  .bus_dbsy (bus_dbsy),
  .bus_drdy (bus_drdy)
);

// File: tb/snoop_capture_agent_tb_top.sv
`timescale 1ns/1ps
module snoop_capture_agent_tb_top;
  localparam int AW = 16;
  localparam int NL = 4;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic trdy = 1'b0;
  logic din_valid = 1'b0;
  logic [63:0] din = '0;
  logic snp_hit, snp_hitm, dbsy, drdy;
  logic [63:0] dout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  snoop_capture_agent #(.ADDR_W(AW), .LINES(NL), .NBEATS(NB)) dut_i (
    .clk(clk), .rst(rst), .bus_req_valid(req_valid), .bus_req_kind(req_kind),
    .bus_req_addr(req_addr), .bus_trdy(trdy), .bus_din_valid(din_valid),
    .bus_din(din), .snp_hit(snp_hit), .snp_hitm(snp_hitm), .bus_dbsy(dbsy),
    .bus_drdy(drdy), .bus_dout(dout)
  );

  function automatic logic [AW-1:0] mk_addr(int tag, int idx);
    return AW'((tag << 7) | (idx << 5) | 3);
  endfunction

  function automatic logic [63:0] pat(int tag, int idx, int beat);
    return {16'h5AC3, 16'(tag), 16'(idx * 16 + 1), 16'(beat * 4099 + 7)};
  endfunction

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic write_back(int tag, int idx);
    req_valid = 1'b1; req_kind = 2'd3; req_addr = mk_addr(tag, idx);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      din_valid = 1'b1; din = pat(tag, idx, b);
      @(negedge clk);
    end
    din_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // issue one lookup and check snoop result and any transfer
  task automatic lookup(string rq, int kind, int tag, int idx, bit e_hit, bit e_hitm);
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = mk_addr(tag, idx);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk({rq, " snp_hit"}, 64'(snp_hit), 64'(e_hit));
    chk({rq, " snp_hitm"}, 64'(snp_hitm), 64'(e_hitm));
    if (e_hitm) begin
      repeat (2) @(negedge clk);
      chk({rq, " R4 idle before trdy"}, 64'(drdy), 64'd0);
      trdy = 1'b1;
      @(negedge clk);
      chk({rq, " R4 no beat one cycle after trdy"}, 64'(drdy), 64'd0);
      for (int b = 0; b < NB; b++) begin
        @(negedge clk);
        chk({rq, " R4 drdy"}, 64'(drdy), 64'd1);
        chk({rq, " R4 dbsy"}, 64'(dbsy), 64'(b < NB - 1));
        chk({rq, " R4 data"}, dout, pat(tag, idx, b));
      end
      trdy = 1'b0;
      @(negedge clk);
      chk({rq, " R4 drdy after burst"}, 64'(drdy), 64'd0);
    end else begin
      int seen = 0;
      trdy = 1'b1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (drdy) seen++;
      end
      trdy = 1'b0;
      chk({rq, " no transfer"}, 64'(seen), 64'd0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: outputs quiet and nothing valid
    chk("R1 hit", 64'(snp_hit), 64'd0);
    chk("R1 hitm", 64'(snp_hitm), 64'd0);
    chk("R1 drdy", 64'(drdy), 64'd0);
    chk("R1 dbsy", 64'(dbsy), 64'd0);
    for (int ix = 0; ix < NL; ix++) lookup("R1 empty read", 0, 0, ix, 0, 0);

    for (int ix = 0; ix < NL; ix++) begin
      int ta = ix * 37 + 5;
      int tb = ix * 53 + 300;
      // R2, R3, R4, R5: capture then claim, then shared
      write_back(ta, ix);
      lookup("R3 owned read", 0, ta, ix, 0, 1);
      lookup("R5 shared read", 0, ta, ix, 1, 0);
      lookup("R8 wrong tag", 0, ta + 1, ix, 0, 0);
      // R6: read-invalidate on shared line
      lookup("R6 rfo shared", 1, ta, ix, 0, 0);
      lookup("R6 after rfo shared", 0, ta, ix, 0, 0);
      // R6: read-invalidate on owned line
      write_back(tb, ix);
      lookup("R6 rfo owned", 1, tb, ix, 0, 1);
      lookup("R6 after rfo owned", 0, tb, ix, 0, 0);
      // R7: zero-byte invalidate
      write_back(ta, ix);
      lookup("R7 inv zero", 2, ta, ix, 0, 0);
      lookup("R7 after inv zero", 0, ta, ix, 0, 0);
      // R2: replacement at the same index
      write_back(ta, ix);
      write_back(tb, ix);
      lookup("R2 evicted tag", 0, ta, ix, 0, 0);
      lookup("R2 new tag", 0, tb, ix, 0, 1);
    end

    // R9: lookup reads the index on the edge the final beat is stored
    req_valid = 1'b1; req_kind = 2'd3; req_addr = mk_addr(77, 2);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      din_valid = 1'b1; din = pat(77, 2, b);
      if (b == NB - 1) begin
        req_valid = 1'b1; req_kind = 2'd0; req_addr = mk_addr(77, 2);
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    din_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 colliding lookup hit", 64'(snp_hit), 64'd0);
    chk("R9 colliding lookup hitm", 64'(snp_hitm), 64'd0);
    repeat (4) @(negedge clk);
    lookup("R9 write completed", 0, 77, 2, 0, 1);

    // R1: reset mid-run drops every line
    write_back(11, 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    lookup("R1 after reset", 0, 11, 1, 0, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule